// File: doc/BRIEF.md
# Bitwise Arbitrating Serial Transmitter

This block is the transmit side of a node on a shared wired-AND serial bus, where a low level overrides a high level. Once a frame-start input arrives, it sends a message of one or more bytes, most significant bit first, presenting one bit per bit slot. A bit strobe marks the end of each slot. The pulse-width and symbol timing are handled outside the block. On every strobe it compares the bit it drove with the bus level read back. If the two differ, the node has lost arbitration and must leave the bus.

A loss inside a byte ends transmission before the next slot. A loss on the final bit of a byte is treated differently. The block first sends up to two extra high bits, and each one is arbitrated like a data bit. This makes sure that a receiver never sees a byte cut short at its boundary. When the last byte finishes without a loss, the block raises a completion pulse.

The message bytes come from an external buffer. The block gives the index of the byte it wants, and the buffer returns that byte as a combinational read.

Top module: `arb_tx`

## Requirements
- R1: While reset is held and just after it, `tx_en`, `lost` and `done` are 0.
- R2: In idle, a `frame_start` high on a clock edge makes `tx_en` 1 from the next cycle, with `byte_idx` = 0 and the first bit slot in progress.
- R3: In a data slot, `tx_bit` equals `byte_data[7 - n]`, where n counts from 0 for the first bit of the byte. Each strobe without a mismatch advances n by one. After n = 7, `byte_idx` increments and n returns to 0.
- R4: If the strobe of bit n = 7 of byte `last_idx` shows no mismatch, then from the next cycle `tx_en` is 0 and `done` is 1 for exactly one cycle.
- R5: A mismatch (`tx_bit` != `bus_rx` at a strobe) on bit n = 0..6 makes `tx_en` 0 from the next cycle, with `lost` high for that one cycle.
- R6: A mismatch on bit n = 7 keeps `tx_en` at 1, keeps `lost` at 0, and drives `tx_bit` = 1 for one extra slot.
- R7: If the first extra slot has a mismatch, the block stops as in R5 and sends no second extra bit.
- R8: If the first extra slot has no mismatch, a second slot with `tx_bit` = 1 follows. After its strobe, the block stops and pulses `lost` whatever the bus value.
- R9: The comparison is made on every byte of the message, not only byte 0.
- R10: `frame_start` has no effect while a frame is in progress.
- R11: `lost` and `done` are never high together and each lasts one cycle. After either, `tx_en` stays 0 until the next `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Begin a frame (used only in idle) |
| bit_strobe | input | 1 | End of the current bit slot; bus sample is valid |
| bus_rx | input | 1 | Bus level read back |
| last_idx | input | IDX_W | Index of the last byte of the message |
| byte_data | input | 8 | Byte at `byte_idx` from the message buffer |
| byte_idx | output | IDX_W | Index of the byte being sent |
| tx_bit | output | 1 | Bit to drive (1 when not driving) |
| tx_en | output | 1 | Drive enable |
| lost | output | 1 | One-cycle pulse when arbitration is lost |
| done | output | 1 | One-cycle pulse when the whole message is sent |

## Verification
A wrong bit position or byte index shows up in the same slot as a wrong `tx_bit`. A wrong byte index may instead show up at the final strobe, as a `done` pulse one byte early or late. A wrong state after a last-bit mismatch shows on the very next cycle: either `tx_en` falls too early or a 0 is driven instead of a 1. A miscounted extension shows one slot later as a missing or extra high slot before `lost`. The sweep places a forced low bit at every slot of messages of every length, combined with every outcome of the two extension slots, so each of these faults appears within the frame that causes it.

// File: rtl/arb_tx.sv
module arb_tx #(
  parameter int MAX_BYTES = 8,
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             bit_strobe,
  input  logic             bus_rx,
  input  logic [IDX_W-1:0] last_idx,
  input  logic [7:0]       byte_data,
  output logic [IDX_W-1:0] byte_idx,
  output logic             tx_bit,
  output logic             tx_en,
  output logic             lost,
  output logic             done
);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_EXT1, S_EXT2} state_t;

  state_t           state;
  logic [2:0]       bit_pos;
  logic [IDX_W-1:0] len_q;
  logic             miss;
  logic             ext_slot;

  assign tx_en    = (state != S_IDLE);
  assign ext_slot = (state == S_EXT1) || (state == S_EXT2);
  assign tx_bit   = (state == S_DATA) ? byte_data[~bit_pos] : 1'b1;
  assign miss     = bit_strobe && tx_en && (tx_bit != bus_rx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bit_pos  <= '0;
      byte_idx <= '0;
      len_q    <= '0;
      lost     <= 1'b0;
      done     <= 1'b0;
    end else begin
      lost <= 1'b0;
      done <= 1'b0;
      case (state)
        S_IDLE: if (frame_start) begin
          state    <= S_DATA;
          bit_pos  <= '0;
          byte_idx <= '0;
          len_q    <= last_idx;
        end
        S_DATA: if (bit_strobe) begin
          bit_pos <= bit_pos + 3'd1;
          if (miss) begin
            if (bit_pos == 3'd7) state <= S_EXT1;
            else begin
              state <= S_IDLE;
              lost  <= 1'b1;
            end
          end else if (bit_pos == 3'd7) begin
            if (byte_idx == len_q) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              byte_idx <= byte_idx + 1'b1;
            end
          end
        end
        S_EXT1: if (bit_strobe) begin
          if (miss) begin
            state <= S_IDLE;
            lost  <= 1'b1;
          end else begin
            state <= S_EXT2;
          end
        end
        S_EXT2: if (bit_strobe) begin
          state <= S_IDLE;
          lost  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/arb_tx_chk.sv
module arb_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       bit_strobe,
  input logic       bus_rx,
  input logic       tx_bit,
  input logic       tx_en,
  input logic       lost,
  input logic       done,
  input logic       ext_slot,
  input logic [2:0] bit_pos
);

  AST_START_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && frame_start) |=> tx_en);  // R2
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_en);  // R4
  AST_EARLY_MISS_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !ext_slot && bit_strobe && (tx_bit != bus_rx) && bit_pos != 3'd7) |=> (lost && !tx_en));  // R5
  AST_LAST_MISS_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !ext_slot && bit_strobe && (tx_bit != bus_rx) && bit_pos == 3'd7) |=> (tx_en && tx_bit && !lost));  // R6
  AST_EXT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ext_slot |-> (tx_en && tx_bit));  // R6
  AST_EXT_MISS_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_slot && bit_strobe && (tx_bit != bus_rx)) |=> (lost && !tx_en));  // R7
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (lost || done) |=> (!lost && !done));  // R11
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(lost && done));  // R11
  AST_STAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !frame_start) |=> !tx_en);  // R11

endmodule

bind arb_tx arb_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bit_strobe(bit_strobe),
  .bus_rx(bus_rx), .tx_bit(tx_bit), .tx_en(tx_en), .lost(lost), .done(done),
  .ext_slot(ext_slot), .bit_pos(bit_pos)
);

// File: tb/sim_arb_tx.sv
`timescale 1ns/1ps
module sim_arb_tx;
  localparam int NB = 4;
  localparam int IW = 2;

  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, bit_strobe = 1'b0, bus_rx = 1'b1;
  logic [IW-1:0] last_idx = '0;
  logic [7:0] mem [NB];
  logic [7:0] byte_data;
  logic [IW-1:0] byte_idx;
  logic tx_bit, tx_en, lost, done;
  int vecs = 0, errs = 0, cyc = 0;

  assign byte_data = mem[byte_idx];

  arb_tx #(.MAX_BYTES(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bit_strobe(bit_strobe),
    .bus_rx(bus_rx), .last_idx(last_idx), .byte_data(byte_data), .byte_idx(byte_idx),
    .tx_bit(tx_bit), .tx_en(tx_en), .lost(lost), .done(done));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000) begin
      errs++;
      $display("FAIL watchdog: run did not end, got %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  // One frame; slot k has a competitor driving low; em picks extension outcome:
  // 0 = competitor low in first extra slot, 1 = low in second, 2 = never low.
  task automatic run(input int len, input int k, input int em);
    int mode = 0, b = 0, p = 0, slot = 0;
    bit fin = 0;
    logic e, comp, bus;
    string tag;
    last_idx = IW'(len - 1);
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    chk("R2", "tx_en after start", tx_en, 1'b1);
    chk("R2", "byte_idx after start", byte_idx[0], 1'b0);
    while (!fin) begin
      if (mode == 0) begin
        e = mem[b][7-p];
        comp = (slot == k) ? 1'b0 : 1'b1;
        chk(b > 0 ? "R9" : "R3", "data tx_bit", tx_bit, e);
      end else begin
        e = 1'b1;
        comp = (mode == 1) ? (em != 0) : (em != 1);
        chk(mode == 1 ? "R6" : "R8", "extra tx_bit", tx_bit, e);
      end
      chk("R3", "tx_en in slot", tx_en, 1'b1);
      bus = e & comp;
      bus_rx = bus;
      bit_strobe = 1'b1;
      @(negedge clk);
      bit_strobe = 1'b0;
      bus_rx = 1'b1;
      tag = "";
      if (mode == 0) begin
        if (e != bus) begin
          if (p == 7) mode = 1;
          else tag = (b > 0) ? "R9" : "R5";
        end else if (p == 7) begin
          if (b == len - 1) tag = "R4";
          else begin b++; p = 0; end
        end else p++;
      end else if (mode == 1) begin
        if (e != bus) tag = "R7";
        else mode = 2;
      end else tag = "R8";
      if (tag != "") begin
        fin = 1;
        chk(tag, "tx_en at stop", tx_en, 1'b0);
        chk(tag, "lost at stop", lost, tag != "R4");
        chk(tag, "done at stop", done, tag == "R4");
        @(negedge clk);
        chk("R11", "lost one cycle", lost, 1'b0);
        chk("R11", "done one cycle", done, 1'b0);
        chk("R11", "idle holds", tx_en, 1'b0);
      end else begin
        if (mode == 1) chk("R6", "no lost at extension", lost, 1'b0);
        if (slot == 3) begin
          frame_start = 1'b1;   // R10: must not restart the frame
          @(negedge clk) frame_start = 1'b0;
          chk("R10", "tx_en after busy start", tx_en, 1'b1);
        end
      end
      slot++;
    end
  endtask

  initial begin
    for (int i = 0; i < NB; i++) mem[i] = 8'hB3 + 8'(i) * 8'h35;
    repeat (3) @(negedge clk);
    chk("R1", "tx_en in reset", tx_en, 1'b0);
    chk("R1", "lost in reset", lost, 1'b0);
    chk("R1", "done in reset", done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "tx_en after reset", tx_en, 1'b0);
    for (int len = 1; len <= NB; len++)
      for (int k = 0; k <= 8 * len; k++)
        for (int em = 0; em < 3; em++)
          run(len, k, em);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule